// File: doc/BRIEF.md
# Indexed Extension Word Decoder

This block turns the extension word of an indexed addressing mode into the two displacements that a later address adder needs. The caller presents the extension word together with a start strobe. The block names the index register it wants on `idx_sel`, and the caller returns that register's contents on `idx_value` in the same cycle. The block sign-extends the index if needed and scales it. It then pulls any further 16-bit displacement words it needs, one at a time, over a ready/valid handshake.

When everything is assembled, the block reports a base displacement, an outer displacement and three flags: base register suppressed, memory-indirect, and illegal encoding. A one-cycle `done` pulse marks the result. Two layouts of the extension word are decoded. The short layout carries an 8-bit displacement inside the word itself. The long layout carries sized base and outer displacements, and a choice of where the index is added. The block does not form the final address and does not perform the indirect memory read.

Top module: `eaxt_decoder`

## Requirements
- R1: After reset, `done`, `busy`, `word_ready`, `base_disp`, `outer_disp`, `base_suppress`, `mem_indirect` and `illegal` are all zero.
- R2: `idx_sel` always equals bits 15:12 of `ext_word`.
- R3: The index is formed as follows. When bit 11 of the extension word is 0, the low 16 bits of `idx_value` are sign-extended to 32 bits. When bit 11 is 1, all 32 bits are used. The index is then shifted left by bits 10:9 of the word, giving a factor of 1, 2, 4 or 8, modulo 2^32.
- R4: When bit 8 is 0 (short layout), the result is as follows. `base_disp` is the index plus the sign-extended bits 7:0. `outer_disp` is 0. All three flags are 0. No further words are requested.
- R5: In the long layout (bit 8 = 1), bits 5:4 give the base displacement size and bits 1:0 give the outer size. Code 1 means a value of zero and no word. Code 2 means one word, sign-extended. Code 3 means two words, the first being the upper half. The base words are fetched before the outer words.
- R6: In the long layout, a base size code of 0 makes the block report `illegal`.
- R7: In the long layout, placement bits {bit 6, bit 2} = 11 make the block report `illegal`. Whenever `illegal` is reported, no words are requested, both displacements are 0, and `base_suppress` and `mem_indirect` are 0.
- R8: Placement {bit 6, bit 2} selects where the index goes. 00 adds the index to the base displacement. 01 adds it to the outer displacement. 10 leaves the index out.
- R9: In a legal long-layout result, `base_suppress` equals bit 7.
- R10: In a legal long-layout result, `mem_indirect` is 1 exactly when bits 1:0 are nonzero.
- R11: `word_ready` is high only while words are still owed. A word is consumed only in a cycle where `word_valid` and `word_ready` are both high. Exactly the number of words the size codes call for is consumed, whatever the stalls on `word_valid`.
- R12: `done` is a single-cycle pulse. The outputs keep their value until the next result. A `start` raised while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin decoding `ext_word` (taken when not busy) |
| ext_word | input | 16 | Indexed-mode extension word |
| idx_sel | output | 4 | Number of the index register to read |
| idx_value | input | 32 | Contents of the selected index register, valid with `start` |
| word_valid | input | 1 | A further extension word is offered |
| word_data | input | 16 | The offered extension word |
| word_ready | output | 1 | Block accepts a further extension word |
| busy | output | 1 | A decode is in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| base_disp | output | 32 | Base displacement (index folded in where selected) |
| outer_disp | output | 32 | Outer displacement (index folded in where selected) |
| base_suppress | output | 1 | Base register is not to be added |
| mem_indirect | output | 1 | An indirect memory read is required |
| illegal | output | 1 | Reserved encoding found |

## Verification
Two things can land on the same clock edge: the acceptance of the last owed displacement word, and a fresh `start` request that must be refused because the block is still busy. The bench provokes this by holding `start` high throughout a fetch, with a different extension word and index value on the inputs. It does this while `word_valid` is either constant or toggling, so the final word can arrive in any cycle. It judges the result by requiring that the reported displacements and flags match the first request exactly and that the word count is unchanged.

// File: rtl/eaxt_pkg.sv
package eaxt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_FIN   = 2'd2
  } eaxt_state_e;

  // size codes of a displacement field
  localparam logic [1:0] SZ_ZERO = 2'd0;  // reserved for base, "not indirect" for outer
  localparam logic [1:0] SZ_NULL = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_LONG = 2'd3;

  // index placement codes {bit6, bit2}
  localparam logic [1:0] PL_PRE  = 2'd0;
  localparam logic [1:0] PL_POST = 2'd1;
  localparam logic [1:0] PL_BAD  = 2'd3;

  localparam int FLD_W = 9;

  // low nine bits of the extension word, kept after start
  typedef struct packed {
    logic       full;
    logic [7:0] low;
  } eaxt_fields_t;

  function automatic logic [1:0] size_words(input logic [1:0] code);
    case (code)
      SZ_WORD: return 2'd1;
      SZ_LONG: return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] base_code(input eaxt_fields_t f);
    return f.low[5:4];
  endfunction

  function automatic logic [1:0] outer_code(input eaxt_fields_t f);
    return f.low[1:0];
  endfunction

  function automatic logic [1:0] place_code(input eaxt_fields_t f);
    return {f.low[6], f.low[2]};
  endfunction

  function automatic logic fmt_illegal(input eaxt_fields_t f);
    return f.full && ((base_code(f) == SZ_ZERO) || (place_code(f) == PL_BAD));
  endfunction

endpackage

// File: rtl/eaxt_index_unit.sv
module eaxt_index_unit #(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 16,
  parameter int SCALE_W = 2
) (
  input  logic [ADDR_W-1:0]  idx_raw,
  input  logic               long_idx,
  input  logic [SCALE_W-1:0] scale,
  output logic [ADDR_W-1:0]  idx_scaled
);
  localparam int EXT_BITS = ADDR_W - WORD_W;

  logic [ADDR_W-1:0] idx_wide;

  always_comb begin
    idx_wide   = long_idx ? idx_raw
                          : {{EXT_BITS{idx_raw[WORD_W-1]}}, idx_raw[WORD_W-1:0]};
    idx_scaled = idx_wide << scale;
  end
endmodule

// File: rtl/eaxt_word_collector.sv
module eaxt_word_collector #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16,
  parameter int NFIELD = 2,
  parameter int CNT_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           load,
  input  logic [NFIELD-1:0][CNT_W-1:0]   need,
  input  logic                           word_valid,
  input  logic [WORD_W-1:0]              word_data,
  output logic                           word_ready,
  output logic [NFIELD-1:0][ADDR_W-1:0]  acc,
  output logic                           last_word
);
  localparam int TOT_W = CNT_W + $clog2(NFIELD);

  logic                          active;
  logic                          accept;
  logic [NFIELD-1:0][CNT_W-1:0]  rem;
  logic [NFIELD:0]               prior_empty;
  logic [NFIELD-1:0]             take;
  logic [TOT_W-1:0]              need_total;
  logic [TOT_W-1:0]              rem_total;

  assign accept         = active && word_valid;
  assign word_ready     = active;
  assign prior_empty[0] = 1'b1;

  always_comb begin
    need_total = '0;
    rem_total  = '0;
    for (int i = 0; i < NFIELD; i++) begin
      need_total = need_total + TOT_W'(need[i]);
      rem_total  = rem_total + TOT_W'(rem[i]);
    end
  end

  assign last_word = accept && (rem_total == TOT_W'(1));

  // one accumulator per displacement field, filled in field order
  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    logic [CNT_W-1:0]  rem_q;
    logic [ADDR_W-1:0] acc_q;

    assign prior_empty[g+1] = prior_empty[g] && (rem_q == '0);
    assign take[g]          = accept && prior_empty[g] && (rem_q != '0);
    assign rem[g]           = rem_q;
    assign acc[g]           = acc_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        rem_q <= '0;
        acc_q <= '0;
      end else if (load) begin
        rem_q <= need[g];
        acc_q <= '0;
      end else if (take[g]) begin
        rem_q <= rem_q - 1'b1;
        acc_q <= {acc_q[ADDR_W-WORD_W-1:0], word_data};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            active <= 1'b0;
    else if (load)      active <= (need_total != '0);
    else if (last_word) active <= 1'b0;
  end

  // R11
  take_has_room_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> (rem_total != '0));

  // R11
  one_taker_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> $onehot0(take));
endmodule

// File: rtl/eaxt_disp_merge.sv
module eaxt_disp_merge
  import eaxt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16
) (
  input  eaxt_fields_t      fld,
  input  logic [ADDR_W-1:0] idx_scaled,
  input  logic [ADDR_W-1:0] base_acc,
  input  logic [ADDR_W-1:0] outer_acc,
  output logic [ADDR_W-1:0] base_val,
  output logic [ADDR_W-1:0] outer_val
);
  localparam int BRIEF_W = 8;

  function automatic logic [ADDR_W-1:0] field_value(input logic [1:0] code,
                                                    input logic [ADDR_W-1:0] a);
    case (code)
      SZ_WORD: return {{(ADDR_W-WORD_W){a[WORD_W-1]}}, a[WORD_W-1:0]};
      SZ_LONG: return a;
      default: return '0;
    endcase
  endfunction

  logic [ADDR_W-1:0] bd_v, od_v, brief_v;

  always_comb begin
    bd_v      = field_value(base_code(fld), base_acc);
    od_v      = field_value(outer_code(fld), outer_acc);
    brief_v   = {{(ADDR_W-BRIEF_W){fld.low[BRIEF_W-1]}}, fld.low};
    base_val  = '0;
    outer_val = '0;
    if (!fld.full) begin
      base_val = idx_scaled + brief_v;
    end else if (!fmt_illegal(fld)) begin
      case (place_code(fld))
        PL_PRE:  begin base_val = bd_v + idx_scaled; outer_val = od_v; end
        PL_POST: begin base_val = bd_v; outer_val = od_v + idx_scaled; end
        default: begin base_val = bd_v; outer_val = od_v; end
      endcase
    end
  end
endmodule

// File: rtl/eaxt_decoder.sv
module eaxt_decoder
  import eaxt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] ext_word,
  output logic [SEL_W-1:0]  idx_sel,
  input  logic [ADDR_W-1:0] idx_value,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ready,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] base_disp,
  output logic [ADDR_W-1:0] outer_disp,
  output logic              base_suppress,
  output logic              mem_indirect,
  output logic              illegal
);
  localparam int NFIELD    = 2;
  localparam int CNT_W     = 2;
  localparam int SCALE_W   = 2;
  localparam int SEL_LSB   = WORD_W - SEL_W;
  localparam int LONG_BIT  = SEL_LSB - 1;
  localparam int SCALE_LSB = LONG_BIT - SCALE_W;

  eaxt_state_e                  st;
  eaxt_fields_t                 fld_in, fld_q;
  logic [ADDR_W-1:0]            idx_now, idx_q;
  logic [NFIELD-1:0][CNT_W-1:0] need;
  logic [NFIELD-1:0][ADDR_W-1:0] acc;
  logic                         load, last_word, fin_ill;
  logic [ADDR_W-1:0]            mrg_base, mrg_outer;

  assign idx_sel = ext_word[WORD_W-1:SEL_LSB];
  assign fld_in  = eaxt_fields_t'(ext_word[FLD_W-1:0]);
  assign load    = start && (st == ST_IDLE);
  assign busy    = (st != ST_IDLE);
  assign fin_ill = fmt_illegal(fld_q);

  always_comb begin
    need = '0;
    if (fld_in.full && !fmt_illegal(fld_in)) begin
      need[0] = size_words(base_code(fld_in));
      need[1] = size_words(outer_code(fld_in));
    end
  end

  eaxt_index_unit #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .SCALE_W(SCALE_W)) u_index (
    .idx_raw   (idx_value),
    .long_idx  (ext_word[LONG_BIT]),
    .scale     (ext_word[LONG_BIT-1:SCALE_LSB]),
    .idx_scaled(idx_now)
  );

  eaxt_word_collector #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .NFIELD(NFIELD), .CNT_W(CNT_W)) u_collect (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .need      (need),
    .word_valid(word_valid),
    .word_data (word_data),
    .word_ready(word_ready),
    .acc       (acc),
    .last_word (last_word)
  );

  eaxt_disp_merge #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_merge (
    .fld       (fld_q),
    .idx_scaled(idx_q),
    .base_acc  (acc[0]),
    .outer_acc (acc[1]),
    .base_val  (mrg_base),
    .outer_val (mrg_outer)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      fld_q         <= '0;
      idx_q         <= '0;
      done          <= 1'b0;
      base_disp     <= '0;
      outer_disp    <= '0;
      base_suppress <= 1'b0;
      mem_indirect  <= 1'b0;
      illegal       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          fld_q <= fld_in;
          idx_q <= idx_now;
          st    <= (need != '0) ? ST_FETCH : ST_FIN;
        end
        ST_FETCH: if (last_word) st <= ST_FIN;
        ST_FIN: begin
          done          <= 1'b1;
          base_disp     <= mrg_base;
          outer_disp    <= mrg_outer;
          illegal       <= fin_ill;
          base_suppress <= fld_q.full && !fin_ill && fld_q.low[7];
          mem_indirect  <= fld_q.full && !fin_ill && (outer_code(fld_q) != SZ_ZERO);
          st            <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R11
  ready_in_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    word_ready |-> (st == ST_FETCH));

  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(base_disp) || !$stable(outer_disp)) |-> done);

  // R7
  illegal_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (done && illegal) |-> (base_disp == '0 && outer_disp == '0 && !mem_indirect && !base_suppress));
endmodule

// File: tb/test_eaxt_decoder.sv
module test_eaxt_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] ext_word = '0;
  logic [3:0]  idx_sel;
  logic [31:0] idx_value = '0;
  logic        word_valid = 1'b0;
  logic [15:0] word_data = '0;
  logic        word_ready, busy, done;
  logic [31:0] base_disp, outer_disp;
  logic        base_suppress, mem_indirect, illegal;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] wq [4];

  eaxt_decoder i_eaxt_decoder (
    .clk(clk), .rst(rst), .start(start), .ext_word(ext_word), .idx_sel(idx_sel),
    .idx_value(idx_value), .word_valid(word_valid), .word_data(word_data),
    .word_ready(word_ready), .busy(busy), .done(done), .base_disp(base_disp),
    .outer_disp(outer_disp), .base_suppress(base_suppress),
    .mem_indirect(mem_indirect), .illegal(illegal)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R12 watchdog expired: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] e, input logic [31:0] v,
                        input bit stall, input bit hold);
    logic [31:0] idxw, sc, bdv, odv, eb, eo;
    logic        ebs, emi, eill, seen, took;
    int          p, nw, ptr;
    string       tb, tf;
    idxw = e[11] ? v : {{16{v[15]}}, v[15:0]};
    sc   = idxw << e[10:9];
    eb = '0; eo = '0; ebs = 0; emi = 0; eill = 0; nw = 0;
    tb = "R3 R4"; tf = "R4";
    if (!e[8]) begin
      eb = sc + {{24{e[7]}}, e[7:0]};
    end else if (e[5:4] == 2'd0 || {e[6], e[2]} == 2'b11) begin
      eill = 1;
      tb = (e[5:4] == 2'd0) ? "R6" : "R7";
      tf = tb;
    end else begin
      p = 0; bdv = '0; odv = '0;
      if (e[5:4] == 2'd2) begin bdv = {{16{wq[0][15]}}, wq[0]}; p = 1; end
      else if (e[5:4] == 2'd3) begin bdv = {wq[0], wq[1]}; p = 2; end
      if (e[1:0] == 2'd2) begin odv = {{16{wq[p][15]}}, wq[p]}; p = p + 1; end
      else if (e[1:0] == 2'd3) begin odv = {wq[p], wq[p+1]}; p = p + 2; end
      nw = p; ebs = e[7]; emi = (e[1:0] != 2'd0);
      case ({e[6], e[2]})
        2'b00:   begin eb = bdv + sc; eo = odv; end
        2'b01:   begin eb = bdv; eo = odv + sc; end
        default: begin eb = bdv; eo = odv; end
      endcase
      tb = "R3 R5 R8"; tf = "R9 R10";
    end

    @(negedge clk);
    ext_word = e; idx_value = v; start = 1'b1;
    #1 chk("R2 idx_sel", 32'(idx_sel), 32'(e[15:12]));
    @(negedge clk);
    if (hold) begin ext_word = 16'h0011; idx_value = 32'h1234_5678; end
    else start = 1'b0;
    ptr = 0; seen = 0;
    for (int c = 0; c < 40; c++) begin
      if (done) begin seen = 1; break; end
      word_valid = stall ? ((c & 1) == 1) : 1'b1;
      word_data  = (ptr < 4) ? wq[ptr] : 16'hDEAD;
      took = word_valid && word_ready;
      @(negedge clk);
      if (took) ptr++;
    end
    start = 1'b0; word_valid = 1'b0;
    chk("R12 done seen", 32'(seen), 32'd1);
    chk(hold ? "R12 start ignored base" : {tb, " base"}, base_disp, eb);
    chk(hold ? "R12 start ignored outer" : {tb, " outer"}, outer_disp, eo);
    chk({tf, " base_suppress R9"}, 32'(base_suppress), 32'(ebs));
    chk({tf, " mem_indirect R10"}, 32'(mem_indirect), 32'(emi));
    chk({tf, " illegal R6/R7"}, 32'(illegal), 32'(eill));
    chk("R11 words consumed", 32'(ptr), 32'(nw));
    @(negedge clk);
    chk("R12 done pulse", 32'(done), 32'd0);
    chk("R12 hold base", base_disp, eb);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 word_ready", 32'(word_ready), 32'd0);
    chk("R1 base", base_disp, 32'd0);
    chk("R1 outer", outer_disp, 32'd0);
    chk("R1 flags", {29'd0, base_suppress, mem_indirect, illegal}, 32'd0);

    // R3 R4: short layout, every displacement byte
    for (int d = 0; d < 256; d++) begin
      logic [15:0] e;
      e = {4'(d), 3'(d >> 5), 1'b0, 8'(d)};
      for (int k = 0; k < 4; k++) wq[k] = 16'(d * 97 + k);
      run_op(e, {8'(d * 7), 8'hA5, 8'(d ^ 8'h80), 8'(d)}, 1'b0, (d % 9) == 0);
    end

    // R5..R11: long layout sweep over scale, width, suppress, placement, sizes
    for (int n = 0; n < 1024; n++) begin
      logic [15:0] e;
      logic [9:0]  b;
      b = 10'(n);
      e = {4'(b[3:0] + b[9:6]), b[2:0], 1'b1, b[3], b[4], b[7:6], b[1], b[5], b[9:8]};
      for (int k = 0; k < 4; k++)
        wq[k] = 16'h8000 ^ (16'(n) * 16'h1357 + 16'(k) * 16'h2468);
      run_op(e, {8'(n * 13), 8'h3C, 8'(n) ^ 8'h91, 8'(n * 5)}, b[0] ^ b[5], (n % 7) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule